// File: doc/BRIEF.md
# Serial configuration bitstream memory (read side)

This block models the read side of a memory that streams a configuration bitstream into a programmable logic device, one bit per configuration clock. A bit array is walked by an internal address counter. Each enabled rising clock edge moves the counter and registers the addressed bit onto the data output. The data line is modelled as a data value plus a separate drive-enable, so that the high-impedance state is a plain signal.

One pin does two jobs. At its reset level it clears the counter and releases the data line. At its enable level it allows the output to drive. Which level means reset is chosen by a configuration input. An active-low chip enable gates counting and selects a low-power standby state. A serial-enable input takes the device out of read mode into programming mode. In that mode the chip enable no longer matters and the read driver stays off. A simple load port fills the array for test. A synchronous active-low reset stands in for the power-on reset.

The array depth is a parameter. Practical values are powers of two from 262,144 to 4,194,304 bits. The default is kept small so that elaboration stays cheap.

Top module: `cfgmem_serial_rd`

## Requirements
- R1: While the reset/enable pin is at its reset level, `dout_oe` is 0 in that same cycle whatever `ce_n` is. At the next clock edge the counter clears to address 0 and the "started" state is dropped.
- R2: With `rstoe_pol`=1, `rstoe_pin`=0 is the reset level and 1 is the enable level. With `rstoe_pol`=0 the two levels swap.
- R3: In read mode (`ser_en`=1), with the pin at its enable level and `ce_n`=0, every rising clock edge is an enabled edge. After the k-th enabled edge since a clear, `dout` holds array bit k-1 and `dout_oe` is 1.
- R4: With `ce_n`=1 in read mode, the counter and `dout` are frozen, `dout_oe` is 0 and `standby` is 1. When `ce_n` returns to 0, reading continues from the next address.
- R5: If `ce_n` stays 1 after a reset pulse, no counting happens and `dout_oe` stays 0. The first enabled edge afterwards presents address 0.
- R6: `rst_n`=0 at a clock edge clears the counter and the started state, giving `dout_oe`=0 and `end_of_data`=0.
- R7: With `ser_en`=0, `prog_mode`=1, `dout_oe`=0 and `standby`=0 whatever `ce_n` is, and the counter does not move.
- R8: Once the last address (DEPTH-1) is presented, `end_of_data` is 1. Further enabled edges keep the counter at that address, so `dout` repeats the last bit.
- R9: `ld_en`=1 at a rising edge writes `ld_bit` into the array at `ld_addr`. A later read of that address returns the new value.
- R10: `dout_oe` is 1 only in read mode, with the pin at its enable level, `ce_n`=0 and at least one enabled edge since the last clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| rstoe_pin | input | 1 | Combined counter reset / output enable pin |
| rstoe_pol | input | 1 | 1: pin low means reset; 0: pin high means reset |
| ce_n | input | 1 | Active-low chip enable |
| ser_en | input | 1 | 1: read mode; 0: programming mode |
| ld_en | input | 1 | Test load write strobe |
| ld_addr | input | $clog2(DEPTH) | Test load bit address |
| ld_bit | input | 1 | Test load bit value |
| dout | output | 1 | Registered configuration data bit |
| dout_oe | output | 1 | Drive enable for the data line (0 = high impedance) |
| standby | output | 1 | Low-power standby indication |
| prog_mode | output | 1 | Programming mode indication |
| end_of_data | output | 1 | Last address is being presented |

## Verification
`dout_oe`, `standby` and `prog_mode` follow the pins in the same cycle, but they also depend on counter state that only changes at a rising edge. `dout` and `end_of_data` change one rising edge after the stimulus that enables a step. The driver sets the pins at a falling edge and holds them across the next rising edge. It then queues the outputs that a model of the requirements gives for the state after that edge. The monitor compares them 1 ns after that rising edge, so every output is sampled with its inputs stable and its register already updated.

// File: rtl/cfgmem_pkg.sv
// Package: shared types for the serial configuration memory read side.
// Assumes: nothing beyond IEEE 1800-2017.
package cfgmem_pkg;

    // Decoded view of the control pins for one cycle.
    typedef struct packed {
        logic rst_lvl;   // pin at its reset level
        logic oe_lvl;    // pin at its enable level
        logic step;      // an enabled edge occurs if clocked now
        logic standby;   // read mode, chip disabled
        logic prog;      // programming mode
    } pin_ctrl_t;

endpackage

// File: rtl/cfgmem_pin_decode.sv
// Module: cfgmem_pin_decode
// Turns the raw pins into the decoded control struct. Purely combinational.
// Assumes: pins are synchronous to the configuration clock.
module cfgmem_pin_decode
    import cfgmem_pkg::*;
(
    input  logic      rstoe_pin,
    input  logic      rstoe_pol,
    input  logic      ce_n,
    input  logic      ser_en,
    output pin_ctrl_t ctrl
);

    logic rst_level;

    // Select which pin level means reset (R2).
    always_comb begin
        if (rstoe_pol) begin
            rst_level = ~rstoe_pin;
        end else begin
            rst_level = rstoe_pin;
        end
    end

    // Build the control view from the mode, chip enable and reset level.
    always_comb begin
        ctrl.rst_lvl = rst_level;
        ctrl.oe_lvl  = ~rst_level;
        ctrl.prog    = ~ser_en;
        ctrl.standby = ser_en & ce_n;
        ctrl.step    = ser_en & ~ce_n & ~rst_level;
    end

endmodule

// File: rtl/cfgmem_addr_ctr.sv
// Module: cfgmem_addr_ctr
// Address counter with a "started" flag. The first enabled edge after a
// clear presents address 0, and each later one presents the next address.
// The counter saturates at the last address.
// Assumes: clr and step are never both high (the decoder guarantees this).
module cfgmem_addr_ctr #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] nxt_o,
    output logic          valid_o,
    output logic          eod_o
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] addr_q;
    logic          valid_q;
    logic [AW-1:0] nxt;

    // Work out the address the next enabled edge will present.
    always_comb begin
        if (!valid_q) begin
            nxt = '0;
        end else if (addr_q == LAST) begin
            nxt = LAST;
        end else begin
            nxt = addr_q + 1'b1;
        end
    end

    // Counter state: clear on reset or the reset level, move on a step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr_q  <= '0;
            valid_q <= 1'b0;
        end else if (step) begin
            addr_q  <= nxt;
            valid_q <= 1'b1;
        end
    end

    assign addr_o  = addr_q;
    assign nxt_o   = nxt;
    assign valid_o = valid_q;
    assign eod_o   = valid_q && (addr_q == LAST);

    // R1
    clr_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (addr_q == '0) && !valid_q);

    // R3
    advance_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && valid_q && addr_q != LAST) |=> addr_q == $past(addr_q) + 1'b1);

    // R4
    frozen_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(addr_q) && $stable(valid_q));

    // R8
    hold_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eod_o && step) |=> (addr_q == LAST) && eod_o);

endmodule

// File: rtl/cfgmem_bit_store.sv
// Module: cfgmem_bit_store
// Single-bit-wide array with a test write port and a registered read.
// A read and a write to the same address in one cycle return the old bit.
// Assumes: the array content is not reset.
module cfgmem_bit_store #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);

    logic mem [DEPTH];
    logic rd_q;

    // Test load port write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_bit;
        end
    end

    // Registered read: capture the addressed bit on an enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
        end else if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

    assign rd_bit = rd_q;

    // R4
    read_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_q));

endmodule

// File: rtl/cfgmem_serial_rd.sv
// Module: cfgmem_serial_rd (top)
// Read side of a serial configuration memory: pin decoding, address counter
// and bit array, with the data line given as a value plus drive enable.
// Assumes: all inputs are synchronous to clk; rst_n models power-on reset.
module cfgmem_serial_rd
    import cfgmem_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rstoe_pin,
    input  logic          rstoe_pol,
    input  logic          ce_n,
    input  logic          ser_en,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic          ld_bit,
    output logic          dout,
    output logic          dout_oe,
    output logic          standby,
    output logic          prog_mode,
    output logic          end_of_data
);

    pin_ctrl_t     ctrl;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] nxt_addr;
    logic          started;
    logic          eod;
    logic          bit_q;

    cfgmem_pin_decode u_dec (
        .rstoe_pin (rstoe_pin),
        .rstoe_pol (rstoe_pol),
        .ce_n      (ce_n),
        .ser_en    (ser_en),
        .ctrl      (ctrl)
    );

    cfgmem_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctrl.rst_lvl),
        .step    (ctrl.step),
        .addr_o  (cur_addr),
        .nxt_o   (nxt_addr),
        .valid_o (started),
        .eod_o   (eod)
    );

    cfgmem_bit_store #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_bit  (ld_bit),
        .rd_en   (ctrl.step),
        .rd_addr (nxt_addr),
        .rd_bit  (bit_q)
    );

    // Drive the data line only in read mode, when enabled and after a bit has been fetched.
    always_comb begin
        dout_oe = ctrl.oe_lvl && !ctrl.prog && !ctrl.standby && started;
    end

    assign dout        = bit_q;
    assign standby     = ctrl.standby;
    assign prog_mode   = ctrl.prog;
    assign end_of_data = eod;

    // R7
    prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |-> !dout_oe && !standby && prog_mode);

    // R7
    prog_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en && !ctrl.rst_lvl) |=> $stable(cur_addr));

    // R10
    oe_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl.rst_lvl) |-> !dout_oe);

endmodule

// File: tb/sim_cfgmem_serial_rd.sv
`timescale 1ns/1ps
module sim_cfgmem_serial_rd;

    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);
    localparam int LAST  = DEPTH - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rstoe_pin = 1'b1;
    logic          rstoe_pol = 1'b1;
    logic          ce_n = 1'b1;
    logic          ser_en = 1'b1;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_bit = 1'b0;
    logic          dout, dout_oe, standby, prog_mode, end_of_data;

    always #2.5 clk = ~clk;

    cfgmem_serial_rd #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .rstoe_pin(rstoe_pin), .rstoe_pol(rstoe_pol),
        .ce_n(ce_n), .ser_en(ser_en), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_bit(ld_bit), .dout(dout), .dout_oe(dout_oe), .standby(standby),
        .prog_mode(prog_mode), .end_of_data(end_of_data)
    );

    typedef struct {
        logic  oe;
        logic  d;
        logic  eod;
        logic  sb;
        logic  pm;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    // Reference model state, built from the requirements.
    logic ref_mem [DEPTH];
    int   m_addr  = 0;
    bit   m_valid = 0;
    logic m_dout  = 1'b0;

    function automatic logic pat(int i);
        return logic'((((i * 37) >> 3) ^ i) & 1);
    endfunction

    // Driver: set pins at a falling edge, update the model, queue the expected outputs.
    task automatic step(input logic rn, input logic pin, input logic pol,
                        input logic ce, input logic se, input logic le,
                        input int la, input logic lb, input string req);
        logic rl;
        exp_t e;
        @(negedge clk);
        rst_n = rn; rstoe_pin = pin; rstoe_pol = pol; ce_n = ce; ser_en = se;
        ld_en = le; ld_addr = AW'(la); ld_bit = lb;
        rl = pol ? ~pin : pin;
        if (!rn || rl) begin
            m_addr = 0; m_valid = 0;
            if (!rn) m_dout = 1'b0;
        end else if (se && !ce) begin
            if (!m_valid) begin
                m_valid = 1; m_addr = 0;
            end else if (m_addr != LAST) begin
                m_addr++;
            end
            m_dout = ref_mem[m_addr];
        end
        if (le) ref_mem[la] = lb;
        e.oe  = se && !rl && !ce && m_valid;
        e.d   = m_dout;
        e.eod = m_valid && (m_addr == LAST);
        e.sb  = se && ce;
        e.pm  = !se;
        e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: compare 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (dout_oe !== e.oe || (e.oe && dout !== e.d) || end_of_data !== e.eod ||
                standby !== e.sb || prog_mode !== e.pm) begin
                fails++;
                $display("FAIL %s: oe=%b d=%b eod=%b sb=%b pm=%b expected oe=%b d=%b eod=%b sb=%b pm=%b",
                         e.req, dout_oe, dout, end_of_data, standby, prog_mode,
                         e.oe, e.d, e.eod, e.sb, e.pm);
            end
        end
    end

    initial begin
        // R9 fill the array through the load port, chip disabled, in power-on reset
        for (int i = 0; i < DEPTH; i++) step(0, 1, 1, 1, 1, 1, i, pat(i), "R9");
        // R6 power-on reset
        for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 1, 0, 0, 0, "R6");
        // R1 reset level with the chip enabled
        for (int i = 0; i < 2; i++) step(1, 0, 1, 0, 1, 0, 0, 0, "R1");
        // R5 chip disabled after the reset pulse: no counting, no drive
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 1, 0, 0, 0, "R5");
        // R3 stream bits from address 0
        for (int i = 0; i < 10; i++) step(1, 1, 1, 0, 1, 0, 0, 0, "R3");
        // R4 standby freezes, then resume
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 1, 0, 0, 0, "R4");
        for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 1, 0, 0, 0, "R4");
        // R7 programming mode ignores chip enable
        step(1, 1, 1, 0, 0, 0, 0, 0, "R7");
        step(1, 1, 1, 1, 0, 0, 0, 0, "R7");
        step(1, 1, 1, 0, 0, 0, 0, 0, "R7");
        for (int i = 0; i < 2; i++) step(1, 1, 1, 0, 1, 0, 0, 0, "R7");
        // R1 reset level wins over a disabled chip
        step(1, 0, 1, 1, 1, 0, 0, 0, "R1");
        // R10 enable level but no enabled edge yet
        step(1, 1, 1, 1, 1, 0, 0, 0, "R10");
        // R8 run past the last address
        for (int i = 0; i < DEPTH + 6; i++) step(1, 1, 1, 0, 1, 0, 0, 0, "R8");
        // R2 inverted polarity: pin high resets, pin low enables
        for (int i = 0; i < 2; i++) step(1, 1, 0, 0, 1, 0, 0, 0, "R2");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 1, 0, 0, 0, "R2");
        // R9 overwrite address 0 and 1 while disabled, then re-read
        step(1, 0, 0, 1, 1, 1, 0, ~pat(0), "R9");
        step(1, 0, 0, 1, 1, 1, 1, ~pat(1), "R9");
        step(1, 1, 0, 1, 1, 0, 0, 0, "R9");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1, 0, 0, 0, "R9");
        // R6 power-on reset mid-stream
        step(0, 0, 0, 0, 1, 0, 0, 0, "R6");
        step(1, 0, 0, 0, 1, 0, 0, 0, "R6");
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule